// File: doc/BRIEF.md
# Privileged Immediate Branch-and-Link Execute Unit

This unit carries out one immediate branch-and-link operation for a 32-bit core that may run with address translation and a user/supervisor split. When it accepts an instruction, it records four things: the branch target, the current program counter, the destination register index and the status word. It then holds busy for a fixed number of cycles. In the last of those cycles it commits all of its results together: a register-file write of the old PC, the new PC, an updated status word and a clear of the load reservation. If the privilege check fails, it instead writes an exception cause.

The branch target is built in one of two ways. By default the 16-bit immediate is sign-extended. If a prefix immediate is pending, it supplies the upper half instead. When debug support is enabled, a target of 0x18 ignores any pending prefix. With the translation option on, user code may take the branch only to one of two software-break entries, at the base vector plus 0x8 or plus 0x18. Taking either entry saves the user-mode and virtual-mode bits and then clears them.

Top module: `brk_link_unit`

## Requirements
- R1: An instruction is accepted on a clock edge where start_i is high and busy_o is low. busy_o then stays high for the whole latency window. A start_i that arrives while busy_o is high is ignored.
- R2: done_o is high for exactly one cycle, the last cycle of the window. All commit strobes (rf_we_o, pc_we_o, stat_we_o, cause_we_o, resv_clr_o, pfx_clr_o) are high only in that cycle.
- R3: With MMU_EN nonzero, status bit 0 (user mode) set, and a target that is neither BASE_VEC+0x8 nor BASE_VEC+0x18, the unit raises cause_we_o with cause_o = 5'b00111. In that case rf_we_o, pc_we_o, stat_we_o and resv_clr_o stay low.
- R4: On a taken branch, rf_we_o is high, rf_idx_o equals the accepted rd index and rf_data_o equals the accepted PC.
- R5: With no prefix pending, pc_o is the sign-extended 16-bit immediate. With pfx_valid_i set, pc_o is {pfx_hi_i, imm_i}.
- R6: On a taken branch, status bit 4 (break in progress) is set unless the target equals 0x18, in which case it keeps its old value.
- R7: resv_clr_o is high on every taken branch.
- R8: With MMU_EN nonzero and the target at BASE_VEC+0x8 or BASE_VEC+0x18, the status word is updated as follows: bit 2 takes the old bit 0, bit 3 takes the old bit 1, and bits 0 and 1 are cleared.
- R9: With DEBUG_EN nonzero and imm_i = 0x0018, the target is 0x18 even when a prefix is pending.
- R10: The window is 3 cycles with AREA_OPT = 0 and 7 cycles otherwise. done_o is first seen in the Nth cycle after the accepting edge.
- R11: pfx_clr_o is high in the final cycle of every instruction, whether the branch was taken or faulted.
- R12: With MMU_EN = 0 there is no privilege fault, and status bits 0 to 3 pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Decode strobe |
| imm_i | input | 16 | Instruction immediate |
| pfx_valid_i | input | 1 | Prefix immediate pending |
| pfx_hi_i | input | 16 | Prefix immediate (upper half) |
| pc_i | input | 32 | PC of this instruction |
| rd_idx_i | input | 5 | Destination register index |
| stat_i | input | 5 | Status word: 0 user, 1 virtual, 2 saved user, 3 saved virtual, 4 break in progress |
| busy_o | output | 1 | Instruction in flight |
| done_o | output | 1 | Final cycle of window |
| rf_we_o | output | 1 | Register write strobe |
| rf_idx_o | output | 5 | Register write index |
| rf_data_o | output | 32 | Register write data (old PC) |
| pc_we_o | output | 1 | PC load strobe |
| pc_o | output | 32 | New PC |
| stat_we_o | output | 1 | Status write strobe |
| stat_o | output | 5 | New status word |
| cause_we_o | output | 1 | Exception cause write strobe |
| cause_o | output | 5 | Exception cause code |
| resv_clr_o | output | 1 | Clear load reservation |
| pfx_clr_o | output | 1 | Consume pending prefix |

## Verification
The bench targets these corner cases:
- User-mode calls to each of the two break entries against a plain user target. A design that mixes these up either faults a legal break or lets user code jump anywhere.
- A pending prefix under a 0x18 immediate. A design that forgets the debug override branches to the prefixed address.
- The 0x18 target, whose break-in-progress bit must not be set.
- A second start during busy. A design that re-accepts it emits two completions.

A second instance, with translation off and the long latency, shows whether the mode bits leak and whether done lands on the seventh cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int unsigned STAT_W    = 5;
  localparam int unsigned ST_USER   = 0;
  localparam int unsigned ST_VIRT   = 1;
  localparam int unsigned ST_USER_S = 2;
  localparam int unsigned ST_VIRT_S = 3;
  localparam int unsigned ST_BRK    = 4;
  localparam logic [4:0]  CAUSE_PRIV = 5'b00111;

  typedef struct packed {
    logic [31:0]       target;
    logic [31:0]       pc;
    logic [4:0]        rd;
    logic [STAT_W-1:0] stat;
  } brk_req_t;
endpackage

// File: rtl/brk_target.sv
module brk_target #(
  parameter int unsigned DEBUG_EN = 1
) (
  input  logic [15:0] imm_i,
  input  logic        pfx_valid_i,
  input  logic [15:0] pfx_hi_i,
  output logic [31:0] target_o
);
  logic dbg_brk;

  generate
    if (DEBUG_EN != 0) begin : g_dbg
      assign dbg_brk = (imm_i == 16'h0018);
    end else begin : g_nodbg
      assign dbg_brk = 1'b0;
    end
  endgenerate

  always_comb begin
    if (dbg_brk)          target_o = 32'h0000_0018;
    else if (pfx_valid_i) target_o = {pfx_hi_i, imm_i};
    else                  target_o = {{16{imm_i[15]}}, imm_i};
  end
endmodule

// File: rtl/brk_decide.sv
module brk_decide
  import brk_pkg::*;
#(
  parameter int unsigned MMU_EN   = 1,
  parameter logic [31:0] BASE_VEC = 32'h0
) (
  input  logic [31:0]       target_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              fault_o,
  output logic [STAT_W-1:0] stat_o
);
  localparam logic [31:0] ENTRY_A = BASE_VEC + 32'h8;
  localparam logic [31:0] ENTRY_B = BASE_VEC + 32'h18;

  logic is_entry;
  assign is_entry = (target_i == ENTRY_A) || (target_i == ENTRY_B);

  always_comb begin
    stat_o = stat_i;
    if (target_i != 32'h18) stat_o[ST_BRK] = 1'b1;
    fault_o = 1'b0;
    if (MMU_EN != 0) begin
      fault_o = stat_i[ST_USER] && !is_entry;
      if (is_entry) begin
        stat_o[ST_USER_S] = stat_i[ST_USER];
        stat_o[ST_USER]   = 1'b0;
        stat_o[ST_VIRT_S] = stat_i[ST_VIRT];
        stat_o[ST_VIRT]   = 1'b0;
      end
    end
  end
endmodule

// File: rtl/brk_seq.sv
module brk_seq #(
  parameter int unsigned LAT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign accept_o = start_i && !busy_q;
  assign busy_o   = busy_q;
  assign done_o   = busy_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r1_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
  a_r2_done_inside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r2_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r10_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/brk_link_unit.sv
module brk_link_unit
  import brk_pkg::*;
#(
  parameter int unsigned MMU_EN   = 1,
  parameter logic [31:0] BASE_VEC = 32'h0,
  parameter int unsigned DEBUG_EN = 1,
  parameter int unsigned AREA_OPT = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [15:0] imm_i,
  input  logic        pfx_valid_i,
  input  logic [15:0] pfx_hi_i,
  input  logic [31:0] pc_i,
  input  logic [4:0]  rd_idx_i,
  input  logic [4:0]  stat_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        rf_we_o,
  output logic [4:0]  rf_idx_o,
  output logic [31:0] rf_data_o,
  output logic        pc_we_o,
  output logic [31:0] pc_o,
  output logic        stat_we_o,
  output logic [4:0]  stat_o,
  output logic        cause_we_o,
  output logic [4:0]  cause_o,
  output logic        resv_clr_o,
  output logic        pfx_clr_o
);
  localparam int unsigned LAT = (AREA_OPT != 0) ? 7 : 3;

  logic        accept;
  logic [31:0] target_d;
  brk_req_t    req_q;
  logic        fault;
  logic [4:0]  stat_new;

  brk_target #(.DEBUG_EN(DEBUG_EN)) u_target (
    .imm_i(imm_i), .pfx_valid_i(pfx_valid_i), .pfx_hi_i(pfx_hi_i),
    .target_o(target_d)
  );

  brk_seq #(.LAT(LAT)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .accept_o(accept), .busy_o(busy_o), .done_o(done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else if (accept) req_q <= '{target: target_d, pc: pc_i, rd: rd_idx_i, stat: stat_i};
  end

  brk_decide #(.MMU_EN(MMU_EN), .BASE_VEC(BASE_VEC)) u_decide (
    .target_i(req_q.target), .stat_i(req_q.stat),
    .fault_o(fault), .stat_o(stat_new)
  );

  assign rf_we_o    = done_o && !fault;
  assign pc_we_o    = done_o && !fault;
  assign stat_we_o  = done_o && !fault;
  assign resv_clr_o = done_o && !fault;
  assign cause_we_o = done_o && fault;
  assign pfx_clr_o  = done_o;
  assign rf_idx_o   = req_q.rd;
  assign rf_data_o  = req_q.pc;
  assign pc_o       = req_q.target;
  assign stat_o     = stat_new;
  assign cause_o    = CAUSE_PRIV;

  a_r3_fault_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_we_o |-> !rf_we_o && !pc_we_o && !stat_we_o && !resv_clr_o);
  a_r2_strobe_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o || cause_we_o || pfx_clr_o) |-> done_o && busy_o);
  a_r11_pfx_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pfx_clr_o && (pc_we_o != cause_we_o));
  a_r1_accept_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r8_modes_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MMU_EN != 0) && stat_we_o && req_q.stat[ST_USER] |-> !stat_o[ST_USER] && stat_o[ST_USER_S]);
endmodule

// File: tb/sim_brk_link_unit.sv
`timescale 1ns/1ps
module sim_brk_link_unit;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic start = 0, pfx_v = 0;
  logic [15:0] imm = 0, pfx_hi = 0;
  logic [31:0] pc = 0;
  logic [4:0] rd = 0, st = 0;

  logic busy0, done0, rfwe0, pcwe0, stwe0, cwe0, rclr0, pclr0;
  logic [4:0] rfi0, sto0, cause0;
  logic [31:0] rfd0, pco0;
  logic busy1, done1, rfwe1, pcwe1, stwe1, cwe1, rclr1, pclr1;
  logic [4:0] rfi1, sto1, cause1;
  logic [31:0] rfd1, pco1;

  int tests = 0, fails = 0;
  bit finished = 0;

  brk_link_unit #(.MMU_EN(1), .BASE_VEC(32'h100), .DEBUG_EN(1), .AREA_OPT(0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .imm_i(imm), .pfx_valid_i(pfx_v),
    .pfx_hi_i(pfx_hi), .pc_i(pc), .rd_idx_i(rd), .stat_i(st), .busy_o(busy0), .done_o(done0),
    .rf_we_o(rfwe0), .rf_idx_o(rfi0), .rf_data_o(rfd0), .pc_we_o(pcwe0), .pc_o(pco0),
    .stat_we_o(stwe0), .stat_o(sto0), .cause_we_o(cwe0), .cause_o(cause0),
    .resv_clr_o(rclr0), .pfx_clr_o(pclr0));

  brk_link_unit #(.MMU_EN(0), .BASE_VEC(32'h100), .DEBUG_EN(1), .AREA_OPT(1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .imm_i(imm), .pfx_valid_i(pfx_v),
    .pfx_hi_i(pfx_hi), .pc_i(pc), .rd_idx_i(rd), .stat_i(st), .busy_o(busy1), .done_o(done1),
    .rf_we_o(rfwe1), .rf_idx_o(rfi1), .rf_data_o(rfd1), .pc_we_o(pcwe1), .pc_o(pco1),
    .stat_we_o(stwe1), .stat_o(sto1), .cause_we_o(cwe1), .cause_o(cause1),
    .resv_clr_o(rclr1), .pfx_clr_o(pclr1));

  // captured at done
  int d0_at, d1_at, d0_cnt, d1_cnt, early_strobe;
  logic busy0_first;
  logic c0_rfwe, c0_pcwe, c0_stwe, c0_cwe, c0_rclr, c0_pclr;
  logic [4:0] c0_rfi, c0_st, c0_cause;
  logic [31:0] c0_rfd, c0_pc;
  logic c1_pcwe, c1_cwe, c1_pclr;
  logic [4:0] c1_st;
  logic [31:0] c1_pc;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] i, input logic pv, input logic [15:0] ph,
                     input logic [31:0] p, input logic [4:0] r, input logic [4:0] s,
                     input int hold);
    @(negedge clk);
    imm = i; pfx_v = pv; pfx_hi = ph; pc = p; rd = r; st = s; start = 1;
    d0_at = 0; d1_at = 0; d0_cnt = 0; d1_cnt = 0; early_strobe = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k >= hold) start = 0;
      if (k == 1) busy0_first = busy0;
      if ((rfwe0 || pcwe0 || cwe0 || pclr0 || rclr0 || stwe0) && !done0) early_strobe++;
      if (done0) begin
        d0_cnt++; d0_at = k;
        c0_rfwe = rfwe0; c0_pcwe = pcwe0; c0_stwe = stwe0; c0_cwe = cwe0;
        c0_rclr = rclr0; c0_pclr = pclr0; c0_rfi = rfi0; c0_st = sto0;
        c0_cause = cause0; c0_rfd = rfd0; c0_pc = pco0;
      end
      if (done1) begin
        d1_cnt++; d1_at = k;
        c1_pcwe = pcwe1; c1_cwe = cwe1; c1_pclr = pclr1; c1_st = sto1; c1_pc = pco1;
      end
    end
  endtask

  task automatic t_reset();
    chk("R1", "busy at reset", {31'b0, busy0}, 0);
    chk("R2", "done at reset", {31'b0, done0 | rfwe0 | cwe0 | pclr0}, 0);
  endtask

  task automatic t_plain();
    run(16'h1234, 0, 16'h0, 32'h4000, 5'd3, 5'b00000, 1);
    chk("R1", "busy after accept", {31'b0, busy0_first}, 1);
    chk("R10", "short latency", d0_at, 3);
    chk("R10", "long latency", d1_at, 7);
    chk("R2", "single done", d0_cnt, 1);
    chk("R2", "no strobe outside done", early_strobe, 0);
    chk("R4", "rf we", {31'b0, c0_rfwe}, 1);
    chk("R4", "rf idx", {27'b0, c0_rfi}, 3);
    chk("R4", "rf data", c0_rfd, 32'h4000);
    chk("R5", "pc sext pos", c0_pc, 32'h0000_1234);
    chk("R6", "brk set", {27'b0, c0_st}, 32'h10);
    chk("R7", "resv clr", {31'b0, c0_rclr}, 1);
    chk("R11", "pfx clr taken", {31'b0, c0_pclr}, 1);
  endtask

  task automatic t_neg_and_prefix();
    run(16'h8004, 0, 16'hFFFF, 32'h10, 5'd1, 5'b00000, 1);
    chk("R5", "pc sext neg", c0_pc, 32'hFFFF_8004);
    run(16'h0010, 1, 16'hABCD, 32'h20, 5'd2, 5'b00000, 1);
    chk("R5", "pc prefixed", c0_pc, 32'hABCD_0010);
  endtask

  task automatic t_user_fault();
    run(16'h0200, 0, 16'h0, 32'h500, 5'd7, 5'b00011, 1);
    chk("R3", "cause we", {31'b0, c0_cwe}, 1);
    chk("R3", "cause code", {27'b0, c0_cause}, 32'h7);
    chk("R3", "no writes", {28'b0, c0_rfwe, c0_pcwe, c0_stwe, c0_rclr}, 0);
    chk("R11", "pfx clr fault", {31'b0, c0_pclr}, 1);
    chk("R12", "no fault mmu off", {30'b0, c1_cwe, c1_pcwe}, 1);
    chk("R12", "modes kept mmu off", {27'b0, c1_st}, 32'h13);
    chk("R12", "pfx clr mmu off", {31'b0, c1_pclr}, 1);
  endtask

  task automatic t_breaks();
    run(16'h0108, 0, 16'h0, 32'h600, 5'd4, 5'b00011, 1);
    chk("R8", "entry+8 taken", {31'b0, c0_pcwe}, 1);
    chk("R8", "entry+8 stat", {27'b0, c0_st}, 32'h1C);
    chk("R12", "entry mmu off stat", {27'b0, c1_st}, 32'h13);
    run(16'h0118, 0, 16'h0, 32'h700, 5'd5, 5'b01001, 1);
    chk("R8", "entry+18 stat", {27'b0, c0_st}, 32'h14);
    chk("R8", "entry+18 pc", c0_pc, 32'h118);
  endtask

  task automatic t_debug_break();
    run(16'h0018, 1, 16'h0001, 32'h800, 5'd6, 5'b00000, 1);
    chk("R9", "prefix ignored", c0_pc, 32'h18);
    chk("R9", "prefix ignored u1", c1_pc, 32'h18);
    chk("R6", "brk not set at 0x18", {27'b0, c0_st}, 32'h0);
  endtask

  task automatic t_busy_start();
    run(16'h0040, 0, 16'h0, 32'h900, 5'd8, 5'b00000, 3);
    chk("R1", "one completion", d0_cnt, 1);
    chk("R1", "one completion u1", d1_cnt, 1);
    chk("R1", "first kept", c0_pc, 32'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_plain();
    t_neg_and_prefix();
    t_user_fault();
    t_breaks();
    t_debug_break();
    t_busy_start();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule